// File: doc/BRIEF.md
# Integer Execute Unit

This unit performs the integer arithmetic and logic work of a 32-bit load/store RISC pipeline. Each cycle it can accept one instruction word together with the two source-register values read for it. It decodes the 6-bit major opcode and chooses the operand format. Where the format calls for it, it widens the 16-bit immediate the way that operation requires. It then returns a result, the destination register index, a write enable, a halt request and a divide-by-zero flag. Branches, memory access, control registers and the register file sit outside the block.

Most operations finish in one cycle. Their outputs are registered on the edge that accepts the instruction. Unsigned divide and remainder go to an iterative divider that produces one quotient bit per clock. The top controller has two states. In `ST_IDLE` it accepts work. On a divide with a non-zero divisor it takes the transition *launch* into `ST_DIVWAIT`, where `busy` is high and `in_valid` is ignored. When the divider reports completion it takes the transition *retire* back to `ST_IDLE` and presents the result. The divider has its own two states. `DV_IDLE` moves to `DV_RUN` on *start*. `DV_RUN` moves back to `DV_IDLE` on *last step*, after 32 iterations, and pulses `done` at that point.

Top module: `rx_exec_unit`

## Requirements
- R1: Bit 31 of `instr` set selects the register form, where the destination is bits 15:11 and the second operand is `opb`. Bit 31 clear selects the immediate form, where the destination is bits 20:16 and the second operand comes from immediate bits 15:0. The major opcode is bits 31:26.
- R2: In the immediate form, add (opcode 13), multiply (opcode 2, low 32 product bits) and the compares (opcodes 25 to 29 and 31) sign-extend the 16-bit immediate.
- R3: In the immediate form, AND (8), OR (14), XOR (6), NOR (1) and XNOR (9) zero-extend the immediate.
- R4: High-half AND (24) and high-half OR (30) place the immediate in bits 31:16 with zeros below it, then combine it with `opa`.
- R5: Shifts use only the low 5 bits of the second operand. The register forms are: left 47, arithmetic right 37, logical right 32. The immediate forms are: left 15, arithmetic right 5, logical right 0, taking the amount from immediate bits 4:0.
- R6: Compares write 1 when true and 0 when false. The register-form opcodes are: equal 57, not equal 63, signed greater 58, signed greater-or-equal 59, unsigned greater-or-equal 60, unsigned greater 61. The immediate forms are those opcodes minus 32.
- R7: A register-form AND (opcode 40) whose bits 25:11 are all zero raises `halt` and leaves `wr_en` low.
- R8: Unsigned divide (35) gives the quotient and unsigned remainder (49) gives the remainder of `opa` by `opb`. Their outputs appear 33 cycles after the cycle that follows the accepting edge, and `out_valid` is high for one cycle.
- R9: A divide or remainder whose `opb` is zero returns in the next cycle with `div_zero` high and `wr_en` low.
- R10: Byte sign-extend (44) copies `opa` bit 7, and halfword sign-extend (55) copies `opa` bit 15, into every higher bit.
- R11: A result whose destination index is 0 has `wr_en` low.
- R12: While `busy` is high, `in_valid` is ignored. No output is produced for it, and the division in flight is not disturbed.
- R13: Every non-divide instruction, and every divide by zero, presents `out_valid` in the cycle right after the accepting edge.
- R14: An opcode outside the supported set (for example 4 or 36) still gives `out_valid`, with `wr_en`, `halt` and `div_zero` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First source register value (bits 25:21) |
| opb | input | 32 | Second source register value (bits 20:16) |
| busy | output | 1 | Divide in flight; input is not accepted |
| out_valid | output | 1 | Outputs below are valid this cycle |
| result | output | 32 | Computed value |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Register write requested |
| halt | output | 1 | Halt request |
| div_zero | output | 1 | Divide-by-zero exception |

## Verification
The bench concentrates on the places where immediates widen. A unit that swapped sign- and zero-extension would return 0x0000FFFF-style values from add and compare, or set the high bits on logic results. A unit that forgot the 16-bit shift on the high-half forms would corrupt the low half instead of the top half. Shift amounts of 33 and 31 expose a shifter that does not mask to five bits, and the mixed-sign compares separate the signed forms from the unsigned ones. On the divide side, the bench checks remainder against quotient selection, the all-ones dividend, and the zero divisor that must not write. It also pokes `in_valid` mid-division, which would yield a stray result or a reloaded divider if the wait state leaked.

// File: rtl/rx_exec_pkg.sv
package rx_exec_pkg;

    localparam int ILEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [4:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_XNOR,
        K_SLL, K_SRA, K_SRL, K_MUL,
        K_CEQ, K_CNE, K_CGT, K_CGE, K_CGTU, K_CGEU,
        K_SXB, K_SXH, K_DIV, K_REM
    } kind_e;

    typedef enum logic [1:0] {
        IMM_SIGN, IMM_ZERO, IMM_HIGH
    } immx_e;

endpackage

// File: rtl/rx_decode.sv
module rx_decode
    import rx_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] opb,
    output kind_e           kind,
    output logic [XLEN-1:0] src_b,
    output logic [RIDX-1:0] rd,
    output logic            halt_req
);
    localparam int PADW = XLEN - 16;

    logic        reg_form;
    logic [5:0]  major;
    logic [15:0] imm16;
    immx_e       immx;
    logic [XLEN-1:0] imm_w;

    assign reg_form = instr[31];
    assign major    = instr[31:26];
    assign imm16    = instr[15:0];
    assign rd       = reg_form ? instr[15:11] : instr[20:16];

    always_comb begin
        kind = K_NONE;
        immx = IMM_ZERO;
        unique case (major)
            6'd0:  kind = K_SRL;
            6'd1:  kind = K_NOR;
            6'd2:  begin kind = K_MUL;  immx = IMM_SIGN; end
            6'd5:  kind = K_SRA;
            6'd6:  kind = K_XOR;
            6'd8:  kind = K_AND;
            6'd9:  kind = K_XNOR;
            6'd13: begin kind = K_ADD;  immx = IMM_SIGN; end
            6'd14: kind = K_OR;
            6'd15: kind = K_SLL;
            6'd24: begin kind = K_AND;  immx = IMM_HIGH; end
            6'd25: begin kind = K_CEQ;  immx = IMM_SIGN; end
            6'd26: begin kind = K_CGT;  immx = IMM_SIGN; end
            6'd27: begin kind = K_CGE;  immx = IMM_SIGN; end
            6'd28: begin kind = K_CGEU; immx = IMM_SIGN; end
            6'd29: begin kind = K_CGTU; immx = IMM_SIGN; end
            6'd30: begin kind = K_OR;   immx = IMM_HIGH; end
            6'd31: begin kind = K_CNE;  immx = IMM_SIGN; end
            6'd32: kind = K_SRL;
            6'd33: kind = K_NOR;
            6'd34: kind = K_MUL;
            6'd35: kind = K_DIV;
            6'd37: kind = K_SRA;
            6'd38: kind = K_XOR;
            6'd40: kind = K_AND;
            6'd41: kind = K_XNOR;
            6'd44: kind = K_SXB;
            6'd45: kind = K_ADD;
            6'd46: kind = K_OR;
            6'd47: kind = K_SLL;
            6'd49: kind = K_REM;
            6'd50: kind = K_SUB;
            6'd55: kind = K_SXH;
            6'd57: kind = K_CEQ;
            6'd58: kind = K_CGT;
            6'd59: kind = K_CGE;
            6'd60: kind = K_CGEU;
            6'd61: kind = K_CGTU;
            6'd63: kind = K_CNE;
            default: kind = K_NONE;
        endcase
    end

    always_comb begin
        unique case (immx)
            IMM_SIGN: imm_w = {{PADW{imm16[15]}}, imm16};
            IMM_HIGH: imm_w = {imm16, {PADW{1'b0}}};
            default:  imm_w = {{PADW{1'b0}}, imm16};
        endcase
    end

    assign src_b    = reg_form ? opb : imm_w;
    assign halt_req = (major == 6'd40) && (instr[25:11] == '0);

endmodule

// File: rtl/rx_alu.sv
module rx_alu
    import rx_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e           kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] amt;
    logic           lt_s, lt_u, eq;

    assign amt  = b[SHW-1:0];
    assign eq   = (a == b);
    assign lt_s = ($signed(a) < $signed(b));
    assign lt_u = (a < b);

    always_comb begin
        y = '0;
        unique case (kind)
            K_ADD:  y = a + b;
            K_SUB:  y = a - b;
            K_AND:  y = a & b;
            K_OR:   y = a | b;
            K_XOR:  y = a ^ b;
            K_NOR:  y = ~(a | b);
            K_XNOR: y = ~(a ^ b);
            K_SLL:  y = a << amt;
            K_SRA:  y = $unsigned($signed(a) >>> amt);
            K_SRL:  y = a >> amt;
            K_MUL:  y = a * b;
            K_CEQ:  y = {{(XLEN-1){1'b0}}, eq};
            K_CNE:  y = {{(XLEN-1){1'b0}}, ~eq};
            K_CGT:  y = {{(XLEN-1){1'b0}}, ~lt_s & ~eq};
            K_CGE:  y = {{(XLEN-1){1'b0}}, ~lt_s};
            K_CGTU: y = {{(XLEN-1){1'b0}}, ~lt_u & ~eq};
            K_CGEU: y = {{(XLEN-1){1'b0}}, ~lt_u};
            K_SXB:  y = {{(XLEN-8){a[7]}}, a[7:0]};
            K_SXH:  y = {{(XLEN-16){a[15]}}, a[15:0]};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rx_divider.sv
module rx_divider #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] quotient,
    output logic [XLEN-1:0] remainder
);
    localparam int CW = $clog2(XLEN) + 1;
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

    typedef enum logic {DV_IDLE, DV_RUN} dv_state_e;

    dv_state_e       state, state_nx;
    logic [CW-1:0]   step;
    logic [XLEN-1:0] quo_q, rem_q, dsr_q;
    logic [XLEN:0]   trial;
    logic            fits;

    assign trial = {rem_q, quo_q[XLEN-1]};
    assign fits  = (trial >= {1'b0, dsr_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DV_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DV_IDLE: if (start)         state_nx = DV_RUN;
            DV_RUN:  if (step == LAST)  state_nx = DV_IDLE;
            default: state_nx = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step  <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                DV_IDLE: if (start) begin
                    step  <= '0;
                    quo_q <= dividend;
                    rem_q <= '0;
                    dsr_q <= divisor;
                end
                DV_RUN: begin
                    rem_q <= fits ? XLEN'(trial - {1'b0, dsr_q}) : trial[XLEN-1:0];
                    quo_q <= {quo_q[XLEN-2:0], fits};
                    step  <= step + 1'b1;
                    if (step == LAST) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state == DV_RUN);
    assign quotient  = quo_q;
    assign remainder = rem_q;

    logic [CW-1:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          run_len <= '0;
        else if (state == DV_IDLE && start)  run_len <= '0;
        else if (state == DV_RUN)            run_len <= run_len + 1'b1;
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == CW'(XLEN)));
    a_r12_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dsr_q));

endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
    import rx_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [4:0]      dest,
    output logic            wr_en,
    output logic            halt,
    output logic            div_zero
);
    typedef enum logic {ST_IDLE, ST_DIVWAIT} top_state_e;

    top_state_e      state, state_nx;
    kind_e           kind;
    logic [XLEN-1:0] src_b, alu_y, quo, rem;
    logic [RIDX-1:0] rd;
    logic            halt_req, is_div, accept, launch, dv_busy, dv_done;
    logic [RIDX-1:0] pend_rd;
    logic            pend_rem;

    rx_decode #(.XLEN(XLEN)) u_dec (
        .instr(instr), .opb(opb), .kind(kind),
        .src_b(src_b), .rd(rd), .halt_req(halt_req)
    );

    rx_alu #(.XLEN(XLEN)) u_alu (
        .kind(kind), .a(opa), .b(src_b), .y(alu_y)
    );

    rx_divider #(.XLEN(XLEN)) u_div (
        .clk(clk), .rst_n(rst_n), .start(launch),
        .dividend(opa), .divisor(opb),
        .busy(dv_busy), .done(dv_done),
        .quotient(quo), .remainder(rem)
    );

    assign is_div = (kind == K_DIV) || (kind == K_REM);
    assign accept = in_valid && (state == ST_IDLE);
    assign launch = accept && is_div && (opb != '0);
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (launch)  state_nx = ST_DIVWAIT;
            ST_DIVWAIT: if (dv_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            dest      <= '0;
            wr_en     <= 1'b0;
            halt      <= 1'b0;
            div_zero  <= 1'b0;
            pend_rd   <= '0;
            pend_rem  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            halt      <= 1'b0;
            div_zero  <= 1'b0;
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    if (launch) begin
                        pend_rd  <= rd;
                        pend_rem <= (kind == K_REM);
                    end else if (is_div) begin
                        out_valid <= 1'b1;
                        result    <= '0;
                        dest      <= rd;
                        div_zero  <= 1'b1;
                    end else begin
                        out_valid <= 1'b1;
                        result    <= alu_y;
                        dest      <= rd;
                        halt      <= halt_req;
                        wr_en     <= (kind != K_NONE) && !halt_req && (rd != '0);
                    end
                end
                ST_DIVWAIT: if (dv_done) begin
                    out_valid <= 1'b1;
                    result    <= pend_rem ? rem : quo;
                    dest      <= pend_rd;
                    wr_en     <= (pend_rd != '0);
                end
                default: ;
            endcase
        end
    end

    a_r7_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (out_valid && !wr_en));
    a_r9_dz_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (out_valid && !wr_en && !halt));
    a_r11_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dest != '0));
    a_r12_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dv_done) |=> !out_valid);
    a_r13_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !launch) |=> out_valid);
    a_r8_wait_tracks_div: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVWAIT) |-> (dv_busy || dv_done));

endmodule

// File: tb/rx_exec_unit_tb.sv
module rx_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, opa = '0, opb = '0;
    logic        busy, out_valid, wr_en, halt, div_zero;
    logic [31:0] result;
    logic [4:0]  dest;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  rd;
        bit          wr, hlt, dz;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .busy(busy), .out_valid(out_valid),
        .result(result), .dest(dest), .wr_en(wr_en), .halt(halt),
        .div_zero(div_zero)
    );

    function automatic logic [31:0] rr(input int op, input int ra, input int rb, input int rd);
        return {op[5:0], ra[4:0], rb[4:0], rd[4:0], 11'b0};
    endfunction

    function automatic logic [31:0] ri(input int op, input int ra, input int rd, input logic [15:0] imm);
        return {op[5:0], ra[4:0], rd[4:0], imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare every produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(0, "R12 stray output", {27'b0, dest, result}, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, {e.tag, " R13 latency"}, 64'(cyc), 64'(e.due));
                check({wr_en, halt, div_zero, dest} == {e.wr, e.hlt, e.dz, e.rd},
                      {e.tag, " flags"}, {56'b0, wr_en, halt, div_zero, dest},
                      {56'b0, e.wr, e.hlt, e.dz, e.rd});
                if (e.wr) check(result == e.res, {e.tag, " result"}, 64'(result), 64'(e.res));
            end
        end
    end

    task automatic send(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] res, input int rd, input bit wr, input bit hlt,
                        input bit dz, input int lat, input string tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        instr = ins; opa = a; opb = b; in_valid = 1'b1;
        e.res = res; e.rd = rd[4:0]; e.wr = wr; e.hlt = hlt; e.dz = dz;
        e.due = cyc + lat; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic alu(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] res, input int rd, input string tag);
        send(ins, a, b, res, rd, rd != 0, 0, 0, 1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !busy && !wr_en && !halt && !div_zero, "reset state",
              {59'b0, out_valid, busy, wr_en, halt, div_zero}, 64'h0);
        rst_n = 1'b1;

        // R1 format and destination fields
        alu(rr(45, 1, 2, 3), 32'd5, 32'd7, 32'd12, 3, "R1 add reg form");
        alu(ri(13, 1, 9, 16'hFFFF), 32'd100, 32'hDEAD, 32'd99, 9, "R1 R2 addi dest 20:16");
        alu(rr(50, 1, 2, 7), 32'd5, 32'd7, 32'hFFFFFFFE, 7, "R1 sub");
        // R2 sign extension
        alu(ri(2, 1, 4, 16'hFFFE), 32'd3, 32'd0, 32'hFFFFFFFA, 4, "R2 muli");
        alu(ri(26, 1, 4, 16'hFFFF), 32'd0, 32'd0, 32'd1, 4, "R2 cmpgi negative imm");
        alu(rr(34, 1, 2, 6), 32'h10001, 32'h10001, 32'h00020001, 6, "R2 mul low bits");
        // R3 zero extension
        alu(ri(8, 1, 5, 16'h8001), 32'hFFFFFFFF, 32'd0, 32'h00008001, 5, "R3 andi");
        alu(ri(9, 1, 5, 16'h00FF), 32'd0, 32'd0, 32'hFFFFFF00, 5, "R3 xnori");
        alu(ri(1, 1, 5, 16'h8000), 32'h10, 32'd0, 32'hFFFF7FEF, 5, "R3 nori");
        alu(ri(14, 1, 5, 16'h8000), 32'h1, 32'd0, 32'h00008001, 5, "R3 ori");
        alu(ri(6, 1, 5, 16'hFFFF), 32'hFFFFFFFF, 32'd0, 32'hFFFF0000, 5, "R3 xori");
        // R4 high half
        alu(ri(24, 1, 8, 16'hFF00), 32'h12345678, 32'd0, 32'h12000000, 8, "R4 andhi");
        alu(ri(30, 1, 8, 16'hABCD), 32'h00000001, 32'd0, 32'hABCD0001, 8, "R4 orhi");
        // R5 shifts
        alu(rr(47, 1, 2, 10), 32'd1, 32'h21, 32'd2, 10, "R5 sl masks amount");
        alu(rr(37, 1, 2, 10), 32'h80000000, 32'd4, 32'hF8000000, 10, "R5 sr arith");
        alu(rr(32, 1, 2, 10), 32'h80000000, 32'd4, 32'h08000000, 10, "R5 sru logical");
        alu(ri(0, 1, 10, 16'h001F), 32'h80000000, 32'd0, 32'd1, 10, "R5 srui");
        alu(ri(5, 1, 10, 16'h001F), 32'h80000000, 32'd0, 32'hFFFFFFFF, 10, "R5 sri");
        alu(ri(15, 1, 10, 16'h0004), 32'h0000000F, 32'd0, 32'h000000F0, 10, "R5 sli");
        // R6 compares
        alu(rr(61, 1, 2, 11), 32'hFFFFFFFF, 32'd1, 32'd1, 11, "R6 cmpgu");
        alu(rr(58, 1, 2, 11), 32'hFFFFFFFF, 32'd1, 32'd0, 11, "R6 cmpg signed");
        alu(rr(57, 1, 2, 11), 32'd9, 32'd9, 32'd1, 11, "R6 cmpe");
        alu(rr(63, 1, 2, 11), 32'd9, 32'd9, 32'd0, 11, "R6 cmpne");
        alu(rr(59, 1, 2, 11), 32'd9, 32'd9, 32'd1, 11, "R6 cmpge equal");
        alu(rr(60, 1, 2, 11), 32'd1, 32'hFFFFFFFF, 32'd0, 11, "R6 cmpgeu");
        alu(ri(28, 1, 11, 16'hFFFF), 32'hFFFFFFFF, 32'd0, 32'd1, 11, "R6 cmpgeui");
        // R7 halt encoding
        send(rr(40, 0, 0, 0), 32'd0, 32'd0, 32'd0, 0, 0, 1, 0, 1, "R7 halt");
        alu(rr(40, 1, 2, 12), 32'hF0F0, 32'hFF00, 32'hF000, 12, "R7 normal and");
        // R10 sign extension
        alu(rr(44, 1, 0, 13), 32'h12345680, 32'd0, 32'hFFFFFF80, 13, "R10 sextb");
        alu(rr(55, 1, 0, 13), 32'h00017FFF, 32'd0, 32'h00007FFF, 13, "R10 sexth");
        // R11 register zero
        send(rr(45, 1, 2, 0), 32'd1, 32'd1, 32'd2, 0, 0, 0, 0, 1, "R11 dest zero");
        // R14 unsupported opcodes
        send(ri(4, 1, 3, 16'h0010), 32'd1, 32'd1, 32'd0, 3, 0, 0, 0, 1, "R14 opcode 4");
        send(rr(36, 1, 2, 3), 32'd1, 32'd1, 32'd0, 3, 0, 0, 0, 1, "R14 opcode 36");
        // R8 divide and remainder
        send(rr(35, 1, 2, 4), 32'd100, 32'd7, 32'd14, 4, 1, 0, 0, 34, "R8 divu");
        send(rr(49, 1, 2, 4), 32'd100, 32'd7, 32'd2, 4, 1, 0, 0, 34, "R8 modu");
        send(rr(35, 1, 2, 4), 32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 4, 1, 0, 0, 34, "R8 divu max");
        send(rr(49, 1, 2, 4), 32'hFFFFFFFF, 32'd10, 32'd5, 4, 1, 0, 0, 34, "R8 modu max");
        send(rr(35, 1, 2, 4), 32'd7, 32'd100, 32'd0, 4, 1, 0, 0, 34, "R8 divu small");
        // R9 divide by zero
        send(rr(35, 1, 2, 4), 32'd7, 32'd0, 32'd0, 4, 0, 0, 1, 1, "R9 divu by zero");
        send(rr(49, 1, 2, 4), 32'd7, 32'd0, 32'd0, 4, 0, 0, 1, 1, "R9 modu by zero");
        // R12 input while busy is ignored
        send(rr(35, 1, 2, 15), 32'd1000, 32'd3, 32'd333, 15, 1, 0, 0, 34, "R12 divu with poke");
        @(negedge clk);
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        instr = rr(45, 1, 2, 20); opa = 32'd1; opb = 32'd1; in_valid = 1'b1;
        @(negedge clk);
        instr = rr(35, 1, 2, 21); opa = 32'd50; opb = 32'd5;
        @(negedge clk);
        in_valid = 1'b0;
        // R11 divide to register zero
        send(rr(35, 1, 2, 0), 32'd9, 32'd3, 32'd3, 0, 0, 0, 0, 34, "R11 divu dest zero");
        alu(rr(45, 1, 2, 3), 32'd1, 32'd1, 32'd2, 3, "R13 add after divide");

        repeat (60) @(negedge clk);
        check(sb.size() == 0, "R12 R13 all results retired", 64'(sb.size()), 64'h0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule